// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of address-space segment descriptors. Each slot pairs an effective-segment word (segment number plus a valid flag) with a virtual-segment word (segment size, two protection keys, a no-execute flag, a page-size code and the virtual segment number). A combinational lookup port turns an effective address into a hit flag, the winning slot and that slot's virtual-segment word, for use by the translation path that follows.

A one-cycle request strobe drives maintenance: storing a slot, reading either word of a slot, a find-by-address that returns the virtual-segment word, invalidating the entry that covers one address (local or global flavour), and invalidating the whole table except slot 0. All results, the error pulse and the flush-request pulses appear one clock after the strobe. Each entry matches according to its own segment size, so 256 MB and 1 TB segments share the table.

Top module: `slb_array`

## Requirements
- R1: After reset every slot holds two all-zero words, no lookup hits, and `err`, `rsp_valid`, `flush_local` and `flush_global` are low.
- R2: An entry whose size field (VSID bits 63:62) is 00 matches an address when its ESID word equals the address with bits 27:0 cleared and bit 27 (the valid flag) set; the lookup port reports hit, slot and VSID word in the same cycle.
- R3: An entry whose size field is 01 matches when its ESID word equals the address with bits 39:0 cleared and bit 27 set; such an entry with any of ESID bits 39:28 set never matches.
- R4: When several slots match, the lowest-numbered one wins.
- R5: A store (opcode 0) takes the slot from RB bits 11:0 and the ESID word from RB with bits 11:0 cleared, and the VSID word from RS; a slot at or beyond the entry count raises `err` and changes nothing.
- R6: A store with any of RB bits 26:12 set raises `err` and leaves the slot unchanged.
- R7: A store whose size field is 10 or 11, or is 01 while `seg1t_en` is low, raises `err` and leaves the slot unchanged.
- R8: The page-size code is {VSID bit 8, VSID bits 5:4}; by default only codes 0, 4 and 5 are accepted, any other raises `err` on a store.
- R9: Reads of the ESID word (opcode 1) or VSID word (opcode 2) use RB bits 11:0 as the slot and return it on `rsp_data` with `rsp_valid` one cycle later; a slot at or beyond the entry count, or opcode 7, raises `err` without `rsp_valid`.
- R10: Find (opcode 3) returns the VSID word of the matching slot, or all ones on a miss; with `mode_64` low, RB bits 63:32 are cleared before matching.
- R11: Invalidate-one (opcode 4 local, 5 global) clears the valid flag of the matching slot and pulses `flush_local` or `flush_global` respectively; a miss changes nothing and pulses neither.
- R12: Invalidate-all (opcode 6) clears the valid flag of every slot except slot 0 and pulses `flush_local` only if one of the cleared slots was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Operation code (0 store, 1 read ESID, 2 read VSID, 3 find, 4 inval local, 5 inval global, 6 inval all) |
| req_rb | input | 64 | Address / slot operand |
| req_rs | input | 64 | VSID word for a store |
| mode_64 | input | 1 | Full-width address for find when high |
| seg1t_en | input | 1 | Allows 1 TB segments to be stored |
| lookup_ea | input | 64 | Effective address for the combinational lookup |
| lookup_hit | output | 1 | Lookup found a matching slot |
| lookup_slot | output | $clog2(NUM_ENTRIES) (5) | Winning slot |
| lookup_vsid | output | 64 | VSID word of the winning slot (zero on a miss) |
| rsp_valid | output | 1 | Read or find result valid |
| rsp_data | output | 64 | Read or find result |
| err | output | 1 | Invalid-operation pulse |
| flush_local | output | 1 | Local translation-cache flush request pulse |
| flush_global | output | 1 | Global translation-cache flush request pulse |

## Verification
Every slot is written with its own 256 MB segment and then looked up, read back and probed with neighbouring unmapped segments, which separates slot decoding from the match compare. 1 TB entries are swept across sixteen 256 MB offsets inside the terabyte, telling a correct size-dependent mask from one that uses the entry's size wrongly. Duplicate segments in two slots separate the priority order from plain hit detection, and all eight page-size codes plus each store rejection reason, each followed by a read-back, show that rejected stores touch nothing.

// File: rtl/slb_pkg.sv
package slb_pkg;

   localparam int WORD_W     = 64;
   localparam int SLOTF_W    = 12;
   localparam int VALID_BIT  = 27;

   localparam logic [WORD_W-1:0] VALID_MASK  = 64'h0000_0000_0800_0000;
   localparam logic [WORD_W-1:0] SEG256_MASK = 64'hFFFF_FFFF_F000_0000;
   localparam logic [WORD_W-1:0] SEG1T_MASK  = 64'hFFFF_FF00_0000_0000;

   localparam logic [1:0] SZ_256M = 2'b00;
   localparam logic [1:0] SZ_1T   = 2'b01;

   typedef enum logic [2:0] {
      OP_STORE     = 3'd0,
      OP_RD_ESID   = 3'd1,
      OP_RD_VSID   = 3'd2,
      OP_FIND      = 3'd3,
      OP_INV_LOCAL = 3'd4,
      OP_INV_GLOB  = 3'd5,
      OP_INV_ALL   = 3'd6,
      OP_BAD       = 3'd7
   } slb_op_e;

endpackage

// File: rtl/slb_match.sv
module slb_match
   import slb_pkg::*;
#(
   parameter int NUM_ENTRIES = 32,
   parameter int SLOT_W      = 5
) (
   input  logic [NUM_ENTRIES-1:0][WORD_W-1:0] esid_words,
   input  logic [NUM_ENTRIES-1:0][1:0]        seg_sizes,
   input  logic [WORD_W-1:0]                  addr,
   output logic                               hit,
   output logic [SLOT_W-1:0]                  slot
);

   logic [WORD_W-1:0]      key_256m;
   logic [WORD_W-1:0]      key_1t;
   logic [NUM_ENTRIES-1:0] hit_vec;

   assign key_256m = (addr & SEG256_MASK) | VALID_MASK;
   assign key_1t   = (addr & SEG1T_MASK)  | VALID_MASK;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
      assign hit_vec[i] = ((esid_words[i] == key_256m) && (seg_sizes[i] == SZ_256M))
                       || ((esid_words[i] == key_1t)   && (seg_sizes[i] == SZ_1T));
   end

   assign hit = |hit_vec;

   always_comb begin
      slot = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) slot = SLOT_W'(i);
      end
   end

endmodule

// File: rtl/slb_store_check.sv
module slb_store_check
   import slb_pkg::*;
#(
   parameter int         NUM_ENTRIES = 32,
   parameter logic [7:0] PSIZE_OK    = 8'b0011_0001
) (
   input  logic [SLOTF_W-1:0] slot_field,
   input  logic [14:0]        resv_field,
   input  logic [1:0]         size_field,
   input  logic [2:0]         psize_code,
   input  logic               seg1t_en,
   output logic               slot_ok,
   output logic               store_ok
);

   localparam logic [SLOTF_W-1:0] LIMIT = SLOTF_W'(NUM_ENTRIES);

   logic resv_ok;
   logic size_ok;
   logic psize_ok;

   assign slot_ok  = slot_field < LIMIT;
   assign resv_ok  = resv_field == '0;
   assign size_ok  = (size_field == SZ_256M) || ((size_field == SZ_1T) && seg1t_en);
   assign psize_ok = PSIZE_OK[psize_code];
   assign store_ok = slot_ok && resv_ok && size_ok && psize_ok;

endmodule

// File: rtl/slb_array.sv
module slb_array
   import slb_pkg::*;
#(
   parameter int         NUM_ENTRIES = 32,
   parameter logic [7:0] PSIZE_OK    = 8'b0011_0001,
   localparam int        SLOT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [63:0]       req_rb,
   input  logic [63:0]       req_rs,
   input  logic              mode_64,
   input  logic              seg1t_en,
   input  logic [63:0]       lookup_ea,
   output logic              lookup_hit,
   output logic [SLOT_W-1:0] lookup_slot,
   output logic [63:0]       lookup_vsid,
   output logic              rsp_valid,
   output logic [63:0]       rsp_data,
   output logic              err,
   output logic              flush_local,
   output logic              flush_global
);

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > (1 << SLOTF_W)) begin : g_bad_depth
      $error("slb_array: NUM_ENTRIES out of range");
   end

   logic [NUM_ENTRIES-1:0][WORD_W-1:0] esid_q;
   logic [NUM_ENTRIES-1:0][WORD_W-1:0] vsid_q;
   logic [NUM_ENTRIES-1:0][1:0]        size_w;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_size
      assign size_w[i] = vsid_q[i][63:62];
   end

   slb_op_e op;
   assign op = slb_op_e'(req_op);

   // lookup port
   logic lk_hit;
   logic [SLOT_W-1:0] lk_slot;

   slb_match #(.NUM_ENTRIES(NUM_ENTRIES), .SLOT_W(SLOT_W)) u_lookup_match (
      .esid_words (esid_q),
      .seg_sizes  (size_w),
      .addr       (lookup_ea),
      .hit        (lk_hit),
      .slot       (lk_slot)
   );

   assign lookup_hit  = lk_hit;
   assign lookup_slot = lk_slot;
   assign lookup_vsid = lk_hit ? vsid_q[lk_slot] : '0;

   // request-side match (find and invalidate-one)
   logic [WORD_W-1:0] op_addr;
   logic              op_hit;
   logic [SLOT_W-1:0] op_slot;

   assign op_addr = (op == OP_FIND && !mode_64) ? {32'h0, req_rb[31:0]} : req_rb;

   slb_match #(.NUM_ENTRIES(NUM_ENTRIES), .SLOT_W(SLOT_W)) u_op_match (
      .esid_words (esid_q),
      .seg_sizes  (size_w),
      .addr       (op_addr),
      .hit        (op_hit),
      .slot       (op_slot)
   );

   // store validation
   logic slot_ok;
   logic store_ok;

   slb_store_check #(.NUM_ENTRIES(NUM_ENTRIES), .PSIZE_OK(PSIZE_OK)) u_store_check (
      .slot_field (req_rb[SLOTF_W-1:0]),
      .resv_field (req_rb[26:12]),
      .size_field (req_rs[63:62]),
      .psize_code ({req_rs[8], req_rs[5:4]}),
      .seg1t_en   (seg1t_en),
      .slot_ok    (slot_ok),
      .store_ok   (store_ok)
   );

   logic [SLOT_W-1:0] rb_slot;
   assign rb_slot = req_rb[SLOT_W-1:0];

   // any valid entry above slot 0
   logic upper_valid;
   always_comb begin
      upper_valid = 1'b0;
      for (int i = 1; i < NUM_ENTRIES; i++) begin
         upper_valid = upper_valid | esid_q[i][VALID_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esid_q       <= '0;
         vsid_q       <= '0;
         rsp_valid    <= 1'b0;
         rsp_data     <= '0;
         err          <= 1'b0;
         flush_local  <= 1'b0;
         flush_global <= 1'b0;
      end else begin
         rsp_valid    <= 1'b0;
         err          <= 1'b0;
         flush_local  <= 1'b0;
         flush_global <= 1'b0;
         if (req_valid) begin
            unique case (op)
               OP_STORE: begin
                  if (store_ok) begin
                     esid_q[rb_slot] <= {req_rb[63:SLOTF_W], {SLOTF_W{1'b0}}};
                     vsid_q[rb_slot] <= req_rs;
                  end else begin
                     err <= 1'b1;
                  end
               end
               OP_RD_ESID, OP_RD_VSID: begin
                  if (slot_ok) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= (op == OP_RD_ESID) ? esid_q[rb_slot] : vsid_q[rb_slot];
                  end else begin
                     err <= 1'b1;
                  end
               end
               OP_FIND: begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= op_hit ? vsid_q[op_slot] : '1;
               end
               OP_INV_LOCAL, OP_INV_GLOB: begin
                  if (op_hit) begin
                     esid_q[op_slot][VALID_BIT] <= 1'b0;
                     flush_local  <= (op == OP_INV_LOCAL);
                     flush_global <= (op == OP_INV_GLOB);
                  end
               end
               OP_INV_ALL: begin
                  for (int i = 1; i < NUM_ENTRIES; i++) begin
                     esid_q[i][VALID_BIT] <= 1'b0;
                  end
                  flush_local <= upper_valid;
               end
               default: err <= 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/slb_array_chk.sv
module slb_array_chk
   import slb_pkg::*;
#(
   parameter int NUM_ENTRIES = 32,
   parameter int SLOT_W      = 5
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               req_valid,
   input logic [2:0]                         req_op,
   input logic [63:0]                        req_rb,
   input logic                               err,
   input logic                               rsp_valid,
   input logic                               flush_local,
   input logic                               flush_global,
   input logic                               lookup_hit,
   input logic [SLOT_W-1:0]                  lookup_slot,
   input logic                               op_hit,
   input logic [NUM_ENTRIES-1:0][WORD_W-1:0] esid_q
);

   localparam logic [SLOTF_W-1:0] LIMIT = SLOTF_W'(NUM_ENTRIES);

   assert_lookup_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_hit |-> esid_q[lookup_slot][VALID_BIT]);

   assert_bad_slot_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd0 && req_rb[SLOTF_W-1:0] >= LIMIT) |=> err);

   assert_err_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!rsp_valid && !flush_local && !flush_global));

   assert_inv_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 3'd4 || req_op == 3'd5) && !op_hit)
      |=> (!flush_local && !flush_global));

   assert_flush_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flush_local, flush_global}));

   assert_slot0_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd6) |=> (esid_q[0] == $past(esid_q[0])));

endmodule

bind slb_array slb_array_chk #(.NUM_ENTRIES(NUM_ENTRIES), .SLOT_W(SLOT_W)) u_slb_array_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .req_rb       (req_rb),
   .err          (err),
   .rsp_valid    (rsp_valid),
   .flush_local  (flush_local),
   .flush_global (flush_global),
   .lookup_hit   (lookup_hit),
   .lookup_slot  (lookup_slot),
   .op_hit       (op_hit),
   .esid_q       (esid_q)
);

// File: tb/slb_array_bench.sv
`timescale 1ns/1ps
module slb_array_bench;

   localparam int N = 32;
   localparam logic [63:0] V = 64'h0800_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic [63:0] req_rb = '0;
   logic [63:0] req_rs = '0;
   logic        mode_64 = 1'b1;
   logic        seg1t_en = 1'b1;
   logic [63:0] lookup_ea = '0;
   logic        lookup_hit;
   logic [4:0]  lookup_slot;
   logic [63:0] lookup_vsid;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic        err;
   logic        flush_local;
   logic        flush_global;

   always #4 clk = ~clk;

   slb_array u_slb_array (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_rb(req_rb), .req_rs(req_rs), .mode_64(mode_64), .seg1t_en(seg1t_en),
      .lookup_ea(lookup_ea), .lookup_hit(lookup_hit), .lookup_slot(lookup_slot),
      .lookup_vsid(lookup_vsid), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .err(err), .flush_local(flush_local), .flush_global(flush_global)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [63:0] m_esid [N];
   logic [63:0] m_vsid [N];

   logic        g_err, g_rv, g_fl, g_fg;
   logic [63:0] g_data;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [2:0] o, input logic [63:0] rb, input logic [63:0] rs);
      @(negedge clk);
      req_valid = 1'b1; req_op = o; req_rb = rb; req_rs = rs;
      @(posedge clk);
      #1;
      g_err = err; g_rv = rsp_valid; g_fl = flush_local; g_fg = flush_global; g_data = rsp_data;
      req_valid = 1'b0;
   endtask

   // model lookup per R2/R3/R4
   task automatic model_find(input logic [63:0] a, output logic h, output int s);
      logic [63:0] k2, k1;
      k2 = (a & 64'hFFFF_FFFF_F000_0000) | V;
      k1 = (a & 64'hFFFF_FF00_0000_0000) | V;
      h = 1'b0; s = 0;
      for (int i = N - 1; i >= 0; i--) begin
         if ((m_esid[i] == k2 && m_vsid[i][63:62] == 2'b00) ||
             (m_esid[i] == k1 && m_vsid[i][63:62] == 2'b01)) begin
            h = 1'b1; s = i;
         end
      end
   endtask

   task automatic check_lookup(input string req, input logic [63:0] a);
      logic h; int s;
      model_find(a, h, s);
      @(negedge clk);
      lookup_ea = a;
      #1;
      chk(req, {63'd0, lookup_hit}, {63'd0, h});
      if (h) begin
         chk(req, {59'd0, lookup_slot}, 64'(s));
         chk(req, lookup_vsid, m_vsid[s]);
      end
   endtask

   task automatic store(input string req, input logic [63:0] rb, input logic [63:0] rs);
      logic ok;
      logic [2:0] ps;
      ps = {rs[8], rs[5:4]};
      ok = (rb[11:0] < 12'(N)) && (rb[26:12] == 15'd0) && (rs[63] == 1'b0)
           && !(rs[62] && !seg1t_en) && (ps == 3'd0 || ps == 3'd4 || ps == 3'd5);
      do_op(3'd0, rb, rs);
      chk(req, {63'd0, g_err}, {63'd0, !ok});
      if (ok) begin
         m_esid[rb[4:0]] = {rb[63:12], 12'h000};
         m_vsid[rb[4:0]] = rs;
      end
   endtask

   task automatic read_check(input string req, input int s);
      do_op(3'd1, 64'(s), 64'd0);
      chk(req, {63'd0, g_rv}, 64'd1);
      chk(req, g_data, m_esid[s]);
      do_op(3'd2, 64'(s), 64'd0);
      chk(req, {63'd0, g_rv}, 64'd1);
      chk(req, g_data, m_vsid[s]);
   endtask

   initial begin
      logic h; int s; bit any;
      for (int i = 0; i < N; i++) begin m_esid[i] = '0; m_vsid[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      check_lookup("R1", 64'h0);
      check_lookup("R1", V);
      chk("R1", {60'd0, err, rsp_valid, flush_local, flush_global}, 64'd0);
      for (int i = 0; i < N; i++) read_check("R1", i);

      // R2/R5/R9: fill every slot with a 256 MB segment
      for (int i = 0; i < N; i++) begin
         store("R5", (64'(i + 1) << 28) | V | 64'(i), (64'(i + 1) << 16) | 64'h600);
         read_check("R9", i);
         check_lookup("R2", (64'(i + 1) << 28) | 64'hABC);
         check_lookup("R2", (64'(i + 1) << 28) | V | 64'h5);
         check_lookup("R2", 64'(i + 40) << 28);
      end

      // R3: 1 TB segment in slot 3
      seg1t_en = 1'b1;
      store("R3", (64'h7 << 40) | V | 64'd3, (64'b01 << 62) | (64'h55 << 16));
      for (int j = 0; j < 16; j++) check_lookup("R3", (64'h7 << 40) | (64'(j) << 28) | 64'h10);
      check_lookup("R3", 64'h8 << 40);
      store("R3", (64'h9 << 40) | (64'h1 << 28) | V | 64'd4, (64'b01 << 62) | 64'h100);
      check_lookup("R3", (64'h9 << 40) | (64'h1 << 28));
      model_find((64'h9 << 40) | (64'h1 << 28), h, s);
      chk("R3", {63'd0, h}, 64'd0);

      // R4: duplicate of slot 6 placed in slot 25
      store("R4", (64'h7 << 28) | V | 64'd25, 64'hABCD_0000);
      check_lookup("R4", 64'h7 << 28);
      chk("R4", {59'd0, lookup_slot}, 64'd6);

      // R11: invalidate-one
      do_op(3'd4, 64'h7 << 28, 64'd0);
      chk("R11", {62'd0, g_fl, g_fg}, 64'b10);
      m_esid[6][27] = 1'b0;
      check_lookup("R11", 64'h7 << 28);
      chk("R11", {59'd0, lookup_slot}, 64'd25);
      do_op(3'd5, 64'h7 << 28, 64'd0);
      chk("R11", {62'd0, g_fl, g_fg}, 64'b01);
      m_esid[25][27] = 1'b0;
      do_op(3'd4, 64'h7 << 28, 64'd0);
      chk("R11", {61'd0, g_fl, g_fg, g_err}, 64'd0);
      read_check("R11", 6);
      read_check("R11", 25);

      // R5..R8: store rejections
      store("R5", (64'h3 << 28) | V | 64'd32, 64'd0);
      store("R5", (64'h3 << 28) | V | 64'd4095, 64'd0);
      store("R6", (64'h3 << 28) | V | (64'h1 << 20) | 64'd10, 64'd0);
      read_check("R6", 10);
      store("R7", (64'h3 << 28) | V | 64'd10, 64'b10 << 62);
      store("R7", (64'h3 << 28) | V | 64'd10, 64'b11 << 62);
      seg1t_en = 1'b0;
      store("R7", (64'h3 << 40) | V | 64'd10, 64'b01 << 62);
      seg1t_en = 1'b1;
      read_check("R7", 10);
      for (int e = 0; e < 8; e++) begin
         store("R8", (64'(e + 100) << 28) | V | 64'd12,
               (64'(e) << 20) | (64'(e >> 2) << 8) | (64'(e & 3) << 4));
         read_check("R8", 12);
      end

      // R9: read errors and undefined opcode
      do_op(3'd1, 64'd32, 64'd0);
      chk("R9", {62'd0, g_err, g_rv}, 64'b10);
      do_op(3'd2, 64'd4095, 64'd0);
      chk("R9", {62'd0, g_err, g_rv}, 64'b10);
      do_op(3'd7, 64'd0, 64'd0);
      chk("R9", {62'd0, g_err, g_rv}, 64'b10);

      // R10: find
      mode_64 = 1'b0;
      do_op(3'd3, 64'hDEAD_BEEF_1000_0000, 64'd0);
      chk("R10", g_data, m_vsid[0]);
      chk("R10", {63'd0, g_rv}, 64'd1);
      mode_64 = 1'b1;
      do_op(3'd3, 64'hDEAD_BEEF_1000_0000, 64'd0);
      chk("R10", g_data, 64'hFFFF_FFFF_FFFF_FFFF);
      for (int i = 1; i < 12; i++) begin
         model_find(64'(i) << 28, h, s);
         do_op(3'd3, 64'(i) << 28, 64'd0);
         chk("R10", g_data, h ? m_vsid[s] : 64'hFFFF_FFFF_FFFF_FFFF);
      end

      // R12: invalidate-all
      any = 1'b0;
      for (int i = 1; i < N; i++) any |= m_esid[i][27];
      do_op(3'd6, 64'd0, 64'd0);
      chk("R12", {62'd0, g_fl, g_fg}, {62'd0, any, 1'b0});
      for (int i = 1; i < N; i++) m_esid[i][27] = 1'b0;
      for (int i = 0; i < N; i++) read_check("R12", i);
      do_op(3'd6, 64'd0, 64'd0);
      chk("R12", {62'd0, g_fl, g_fg}, 64'd0);
      check_lookup("R12", 64'h1 << 28);
      chk("R12", {63'd0, lookup_hit}, 64'd1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule